// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

One DMA channel that moves a run of elements between a fixed device address and a block of memory. Both addresses sit in the space of a single word-wide request/acknowledge master. The engine reads each element from the source and then writes it to the destination. After every element the memory address steps forward by the element width. The device address never moves.

The channel runs in one of two modes.

- **Direct mode:** software loads four live registers (device address, memory address, size, link) through the configuration port. A start pulse then runs that one transfer.
- **Chained mode:** software loads only the link register. The engine then fetches four-word descriptors from memory into the live registers and follows each link until a descriptor says stop.

Each descriptor carries its own element width and its own end/follow and interrupt code. The channel reports a two-bit activity code. It signals the end of a descriptor that asks for an interrupt with a one-cycle pulse, and signals an illegal size with a one-cycle error pulse.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status code is 0, no bus request is raised, `done_o` and `err_o` are low, and all four live registers read 0.
- R2: `cfg_sel_i` selects a live register: 0 device address, 1 memory address, 2 size, 3 link. `cfg_rdata_o` shows the selected one. A `cfg_we_i` write is taken only while the status is 0 and is ignored otherwise.
- R3: A `start_i` pulse is accepted only while idle. With `mode_i`=2 it runs the live transfer directly. With `mode_i`=1 it fetches a descriptor from the link register with its low two bits cleared. Descriptor words at byte offsets 0, 4, 8 and 12 load the device, memory, size and link registers. A start with mode 0 or 3, or any start while busy, has no effect.
- R4: In the size word, bits 10:0 are the element count and bits 13:12 the width code: 3 means 1 byte, 2 means 2 bytes, 0 means 4 bytes, and 1 is invalid.
- R5: A count of zero, a count above 0x3FF for 1- or 2-byte widths, a count above 0x7FF for 4-byte width, or width code 1 makes the channel raise `err_o` for one cycle and return to idle without any data access.
- R6: With `dir_i`=1 each element is read at the memory address and written to the device address. With `dir_i`=0 it is read at the device address and written to the memory address. After each element the memory register grows by the width in bytes, and the device register is unchanged.
- R7: Written data keeps only the low 8 or 16 bits for 1- or 2-byte elements. `mem_wsz_o` is 0, 1 or 2 for 1, 2 or 4 bytes on data accesses.
- R8: When a descriptor finishes, `done_o` pulses for one cycle if bit 0 of its link word is 1, and stays low if that bit is 0.
- R9: In chained mode, when a finished descriptor has bit 1 of its link word set, the next descriptor is fetched from the link with its low two bits cleared. When that bit is 0 the channel goes idle.
- R10: A direct-mode transfer ends in idle after its one descriptor, even when its link code asks to follow.
- R11: Driving `mode_i` to 0 while busy returns the channel to idle on the next cycle. After that there are no further requests and no done or error pulse.
- R12: The status code is 1 while fetching a descriptor, 3 while reading or writing an element, 2 in the check and finish steps between them, and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Run mode: 0 off/abort, 1 chained, 2 direct |
| dir_i | input | 1 | 1 memory-to-device, 0 device-to-memory |
| start_i | input | 1 | Start pulse |
| cfg_we_i | input | 1 | Live register write strobe |
| cfg_sel_i | input | 2 | Live register select |
| cfg_wdata_i | input | 32 | Live register write data |
| cfg_rdata_o | output | 32 | Selected live register |
| mem_req_o | output | 1 | Bus request, held until acknowledge |
| mem_we_o | output | 1 | Bus write enable |
| mem_addr_o | output | 32 | Bus byte address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_wsz_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_ack_i | input | 1 | Bus acknowledge |
| mem_rdata_i | input | 32 | Bus read data, valid with acknowledge |
| status_o | output | 2 | Activity code |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Illegal-size pulse |

## Verification
Most internal faults show up on the bus within one element.

- A wrong address step, a wrong mask or a swapped direction gives a write whose address or data does not match the next item in the scoreboard.
- A wrong fetch offset loads the wrong field, so the next transfer writes to the wrong places.
- A broken chain decision, a lost interrupt bit or a faulty legality check changes the done and error pulse counts, or the number of writes. These are read as soon as the status returns to idle.

Abort and ignored-input faults are caught within one cycle by checking the status and the absence of requests.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 11;
  localparam int unsigned WC_LSB = 12;
  localparam int unsigned NREG   = 4;
  localparam logic [CNT_W-1:0] MAX_NARROW = CNT_W'(12'h3FF);
  localparam logic [CNT_W-1:0] MAX_WIDE   = CNT_W'(12'h7FF);

  typedef enum logic [1:0] {MODE_OFF = 2'd0, MODE_LIST = 2'd1, MODE_ONCE = 2'd2} mode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DESC = 2'd1, ST_WAIT = 2'd2, ST_XFER = 2'd3} stat_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_FINISH} state_e;
  typedef enum logic [1:0] {REG_DEV = 2'd0, REG_MEM = 2'd1, REG_SIZE = 2'd2, REG_NEXT = 2'd3} reg_sel_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] wc);
    case (wc)
      2'd3:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] elem_mask(input logic [1:0] wc);
    case (wc)
      2'd3:    return WORD_W'(32'h0000_00FF);
      2'd2:    return WORD_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic size_legal(input logic [WORD_W-1:0] sz);
    logic [1:0]       wc;
    logic [CNT_W-1:0] c;
    wc = sz[WC_LSB +: 2];
    c  = sz[CNT_W-1:0];
    if (wc == 2'd1) return 1'b0;
    if (c == '0) return 1'b0;
    if (wc == 2'd0) return c <= MAX_WIDE;
    return c <= MAX_NARROW;
  endfunction

  function automatic logic [WORD_W-1:0] link_ptr(input logic [WORD_W-1:0] nx);
    return {nx[WORD_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/dma_chain_regs.sv
`timescale 1ns/1ps
module dma_chain_regs
  import dma_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_sel_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              load_i,
  input  logic [1:0]        load_sel_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              adv_i,
  input  logic [2:0]        adv_bytes_i,
  output logic [WORD_W-1:0] dev_o,
  output logic [WORD_W-1:0] mem_o,
  output logic [WORD_W-1:0] size_o,
  output logic [WORD_W-1:0] next_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (load_i && load_sel_i == 2'(g)) begin
        regs_q[g] <= load_data_i;
      end else if (host_we_i && idle_i && host_sel_i == 2'(g)) begin
        regs_q[g] <= host_wdata_i;
      end else if (g == int'(REG_MEM) && adv_i) begin
        regs_q[g] <= regs_q[g] + WORD_W'(adv_bytes_i);
      end
    end
  end

  assign dev_o   = regs_q[REG_DEV];
  assign mem_o   = regs_q[REG_MEM];
  assign size_o  = regs_q[REG_SIZE];
  assign next_o  = regs_q[REG_NEXT];
  assign rdata_o = regs_q[host_sel_i];

  AST_DEV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !load_i) |=> $stable(regs_q[REG_DEV])); // R6
endmodule

// File: rtl/dma_chain_fsm.sv
`timescale 1ns/1ps
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [WORD_W-1:0] size_i,
  input  logic [WORD_W-1:0] next_i,
  output state_e            state_o,
  output logic [1:0]        idx_o,
  output logic [WORD_W-1:0] ptr_o,
  output logic [WORD_W-1:0] data_o,
  output logic [1:0]        status_o,
  output logic              idle_o,
  output logic              load_o,
  output logic              adv_o,
  output logic              done_o,
  output logic              err_o
);
  state_e            state_q;
  logic [1:0]        idx_q;
  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] data_q;
  logic [CNT_W-1:0]  rem_q;
  logic              once_q;
  logic              done_q;
  logic              err_q;
  logic              abort;

  assign abort = (state_q != S_IDLE) && (mode_i == MODE_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      rem_q   <= '0;
      once_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort) begin
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (start_i) begin
            if (mode_i == MODE_ONCE) begin
              once_q  <= 1'b1;
              state_q <= S_CHECK;
            end else if (mode_i == MODE_LIST) begin
              once_q  <= 1'b0;
              idx_q   <= '0;
              ptr_q   <= link_ptr(next_i);
              state_q <= S_FETCH;
            end
          end
          S_FETCH: if (mem_ack_i) begin
            idx_q <= idx_q + 2'd1;
            if (idx_q == 2'd3) state_q <= S_CHECK;
          end
          S_CHECK: begin
            if (!size_legal(size_i)) begin
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              rem_q   <= size_i[CNT_W-1:0];
              state_q <= S_READ;
            end
          end
          S_READ: if (mem_ack_i) begin
            data_q  <= mem_rdata_i;
            state_q <= S_WRITE;
          end
          S_WRITE: if (mem_ack_i) begin
            rem_q   <= rem_q - CNT_W'(1);
            state_q <= (rem_q == CNT_W'(1)) ? S_FINISH : S_READ;
          end
          S_FINISH: begin
            done_q <= next_i[0];
            // follow only in chained runs
            if (next_i[1] && !once_q) begin
              idx_q   <= '0;
              ptr_q   <= link_ptr(next_i);
              state_q <= S_FETCH;
            end else begin
              state_q <= S_IDLE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:          status_o = ST_IDLE;
      S_FETCH:         status_o = ST_DESC;
      S_READ, S_WRITE: status_o = ST_XFER;
      default:         status_o = ST_WAIT;
    endcase
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign ptr_o   = ptr_q;
  assign data_o  = data_q;
  assign idle_o  = (state_q == S_IDLE);
  assign load_o  = (state_q == S_FETCH) && mem_ack_i && !abort;
  assign adv_o   = (state_q == S_WRITE) && mem_ack_i && !abort;
  assign done_o  = done_q;
  assign err_o   = err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (state_q == S_IDLE && !done_q && !err_q)); // R11
  AST_REM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READ) |-> (rem_q != '0)); // R5
endmodule

// File: rtl/dma_chain_bus.sv
`timescale 1ns/1ps
module dma_chain_bus
  import dma_chain_pkg::*;
(
  input  state_e            state_i,
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] ptr_i,
  input  logic [WORD_W-1:0] dev_i,
  input  logic [WORD_W-1:0] mem_i,
  input  logic              dir_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [1:0]        wc_i,
  output logic              req_o,
  output logic              we_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [1:0]        wsz_o
);
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    wsz_o   = 2'd2;
    case (state_i)
      S_FETCH: begin
        req_o  = 1'b1;
        addr_o = ptr_i + WORD_W'({idx_i, 2'b00});
      end
      S_READ: begin
        req_o  = 1'b1;
        addr_o = dir_i ? mem_i : dev_i;
        wsz_o  = elem_bytes(wc_i) == 3'd1 ? 2'd0 : (elem_bytes(wc_i) == 3'd2 ? 2'd1 : 2'd2);
      end
      S_WRITE: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = dir_i ? dev_i : mem_i;
        wdata_o = data_i & elem_mask(wc_i);
        wsz_o   = elem_bytes(wc_i) == 3'd1 ? 2'd0 : (elem_bytes(wc_i) == 3'd2 ? 2'd1 : 2'd2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_chain_chan.sv
`timescale 1ns/1ps
module dma_chain_chan
  import dma_chain_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  mode_i,
  input  logic        dir_i,
  input  logic        start_i,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [1:0]  mem_wsz_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic [1:0]  status_o,
  output logic        done_o,
  output logic        err_o
);
  state_e            state;
  logic [1:0]        idx;
  logic [WORD_W-1:0] ptr, data, dev, mem, size, next;
  logic              idle, load, adv;

  dma_chain_fsm i_fsm (
    .clk_i, .rst_ni, .mode_i, .start_i, .mem_ack_i, .mem_rdata_i,
    .size_i(size), .next_i(next),
    .state_o(state), .idx_o(idx), .ptr_o(ptr), .data_o(data),
    .status_o, .idle_o(idle), .load_o(load), .adv_o(adv),
    .done_o, .err_o
  );

  dma_chain_regs i_regs (
    .clk_i, .rst_ni, .idle_i(idle),
    .host_we_i(cfg_we_i), .host_sel_i(cfg_sel_i), .host_wdata_i(cfg_wdata_i),
    .load_i(load), .load_sel_i(idx), .load_data_i(mem_rdata_i),
    .adv_i(adv), .adv_bytes_i(elem_bytes(size[WC_LSB +: 2])),
    .dev_o(dev), .mem_o(mem), .size_o(size), .next_o(next), .rdata_o(cfg_rdata_o)
  );

  dma_chain_bus i_bus (
    .state_i(state), .idx_i(idx), .ptr_i(ptr), .dev_i(dev), .mem_i(mem),
    .dir_i, .data_i(data), .wc_i(size[WC_LSB +: 2]),
    .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .wsz_o(mem_wsz_o)
  );

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_IDLE) |-> !mem_req_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && mode_i != MODE_OFF) |=> (mem_req_o && $stable(mem_addr_o))); // R12
endmodule

// File: tb/test_dma_chain_chan.sv
`timescale 1ns/1ps
module test_dma_chain_chan;
  typedef struct packed {logic [31:0] a; logic [31:0] d; logic [1:0] z;} wr_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  mode = 2'd0, cfg_sel = 2'd0;
  logic        dir = 1'b0, start = 1'b0, cfg_we = 1'b0, mem_ack = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, mem_addr, mem_wdata, mem_rdata = '0;
  logic        mem_req, mem_we, done, err;
  logic [1:0]  mem_wsz, status;

  logic [31:0] mem_w [256];
  wr_t         exp_q [$];
  int n_chk = 0, n_err = 0, wr_cnt = 0, done_n = 0, err_n = 0;
  int dev_rd_n = 0, dev_pred = 0;
  bit sb_on = 1'b1;

  always #2 clk = ~clk;

  dma_chain_chan i_dma_chain_chan (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dir_i(dir), .start_i(start),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wsz_o(mem_wsz), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .status_o(status), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        wr_cnt++;
        if (!mem_addr[31]) mem_w[mem_addr[9:2]] = mem_wdata;
        if (sb_on) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected write", mem_addr, 32'h0);
          end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(mem_addr == e.a, "R6 write address", mem_addr, e.a);
            chk(mem_wdata == e.d, "R7 write data", mem_wdata, e.d);
            chk(mem_wsz == e.z, "R7 write size", 32'(mem_wsz), 32'(e.z));
          end
        end
      end else if (mem_addr[31]) begin
        mem_rdata = 32'hD000_0000 | 32'(dev_rd_n);
        dev_rd_n++;
      end else begin
        mem_rdata = mem_w[mem_addr[9:2]];
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (done) done_n++;
    if (err) err_n++;
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  task automatic load_live(input logic [31:0] dv, input logic [31:0] m, input logic [31:0] sz, input logic [31:0] nx);
    cfg_write(2'd0, dv); cfg_write(2'd1, m); cfg_write(2'd2, sz); cfg_write(2'd3, nx);
  endtask

  task automatic expect_run(input bit d, input logic [31:0] dv, input logic [31:0] m, input int cnt, input logic [1:0] wc);
    int b;
    logic [31:0] msk;
    logic [1:0] z;
    b   = (wc == 2'd3) ? 1 : (wc == 2'd2) ? 2 : 4;
    msk = (wc == 2'd3) ? 32'hFF : (wc == 2'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    z   = (wc == 2'd3) ? 2'd0 : (wc == 2'd2) ? 2'd1 : 2'd2;
    for (int i = 0; i < cnt; i++) begin
      wr_t e;
      logic [31:0] ma;
      ma = m + 32'(i * b);
      if (d) begin
        e.a = dv; e.d = mem_w[ma[9:2]] & msk;
      end else begin
        e.a = ma; e.d = (32'hD000_0000 | 32'(dev_pred)) & msk; dev_pred++;
      end
      e.z = z;
      exp_q.push_back(e);
    end
  endtask

  task automatic kick(input logic [1:0] m);
    mode = m; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000 && status != 2'd0; i++) tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w0, d0, e0;
    for (int i = 0; i < 256; i++) mem_w[i] = (32'(i) * 32'h0101_0107) ^ 32'h5A5A_0000;
    repeat (3) tick();
    // R1 reset state
    chk(status == 2'd0, "R1 status", 32'(status), 0);
    chk(!mem_req, "R1 request", 32'(mem_req), 0);
    chk(!done && !err, "R1 pulses", {30'd0, done, err}, 0);
    for (int s = 0; s < 4; s++) begin
      cfg_read(2'(s), rd);
      chk(rd == 32'h0, "R1 live register", rd, 0);
    end
    rst_n = 1'b1;
    tick();

    // direct, memory to device, 4-byte, irq
    dir = 1'b1;
    load_live(32'h8000_0020, 32'h40, 32'h0000_0003, 32'h1);
    expect_run(1'b1, 32'h8000_0020, 32'h40, 3, 2'd0);
    kick(2'd2);
    chk(status == 2'd2, "R12 check step status", 32'(status), 2);
    tick();
    chk(status == 2'd3, "R12 access status", 32'(status), 3);
    wait_idle();
    chk(done_n == 1, "R8 done with irq code", done_n, 1);
    chk(exp_q.size() == 0, "R6 all elements moved", exp_q.size(), 0);
    cfg_read(2'd1, rd); chk(rd == 32'h4C, "R6 memory address advance", rd, 32'h4C);
    cfg_read(2'd0, rd); chk(rd == 32'h8000_0020, "R6 device address fixed", rd, 32'h8000_0020);

    // direct, device to memory, 1-byte, no irq
    dir = 1'b0;
    load_live(32'h8000_0030, 32'h200, 32'h0000_3002, 32'h0);
    expect_run(1'b0, 32'h8000_0030, 32'h200, 2, 2'd3);
    kick(2'd2);
    wait_idle();
    chk(done_n == 1, "R8 no done without irq code", done_n, 1);
    chk(exp_q.size() == 0, "R7 byte elements", exp_q.size(), 0);
    cfg_read(2'd1, rd); chk(rd == 32'h202, "R6 byte step", rd, 32'h202);

    // chained, two descriptors, device to memory
    mem_w[8'h40] = 32'h8000_0010; mem_w[8'h41] = 32'h300; mem_w[8'h42] = 32'h0000_2003; mem_w[8'h43] = 32'h142;
    mem_w[8'h50] = 32'h8000_0010; mem_w[8'h51] = 32'h380; mem_w[8'h52] = 32'h0000_0002; mem_w[8'h53] = 32'h1;
    cfg_write(2'd3, 32'h101);
    expect_run(1'b0, 32'h8000_0010, 32'h300, 3, 2'd2);
    expect_run(1'b0, 32'h8000_0010, 32'h380, 2, 2'd0);
    kick(2'd1);
    chk(status == 2'd1, "R3 chained start fetches, R12 status", 32'(status), 1);
    wait_idle();
    chk(done_n == 2, "R9 one done at chain end", done_n, 2);
    chk(exp_q.size() == 0, "R9 both descriptors run", exp_q.size(), 0);
    cfg_read(2'd1, rd); chk(rd == 32'h388, "R9 live memory register", rd, 32'h388);
    cfg_read(2'd3, rd); chk(rd == 32'h1, "R3 link loaded from descriptor", rd, 32'h1);

    // chained, single descriptor ending without irq
    mem_w[8'h60] = 32'h8000_0040; mem_w[8'h61] = 32'h3C0; mem_w[8'h62] = 32'h0000_2001; mem_w[8'h63] = 32'h100;
    cfg_write(2'd3, 32'h180);
    expect_run(1'b0, 32'h8000_0040, 32'h3C0, 1, 2'd2);
    kick(2'd1);
    wait_idle();
    chk(done_n == 2, "R8 chain end without irq", done_n, 2);
    chk(exp_q.size() == 0, "R9 end code stops", exp_q.size(), 0);

    // direct run with follow code stays single
    dir = 1'b1;
    load_live(32'h8000_0050, 32'h10, 32'h0000_0001, 32'h103);
    expect_run(1'b1, 32'h8000_0050, 32'h10, 1, 2'd0);
    w0 = wr_cnt;
    kick(2'd2);
    wait_idle();
    repeat (6) tick();
    chk(status == 2'd0, "R10 idle after direct run", 32'(status), 0);
    chk(wr_cnt - w0 == 1, "R10 single element", wr_cnt - w0, 1);
    chk(done_n == 3, "R10 irq code honoured", done_n, 3);

    // illegal sizes
    begin
      logic [31:0] bad [4];
      bad[0] = 32'h0000_0000; bad[1] = 32'h0000_3400; bad[2] = 32'h0000_1005; bad[3] = 32'h0000_2400;
      for (int k = 0; k < 4; k++) begin
        w0 = wr_cnt; d0 = done_n; e0 = err_n;
        load_live(32'h8000_0050, 32'h10, bad[k], 32'h1);
        kick(2'd2);
        wait_idle();
        chk(err_n == e0 + 1, "R5 error pulse", err_n, e0 + 1);
        chk(wr_cnt == w0, "R5 no data access", wr_cnt, w0);
        chk(done_n == d0, "R5 no done", done_n, d0);
      end
    end

    // legal boundaries
    e0 = err_n;
    load_live(32'h8000_0060, 32'h0, 32'h0000_33FF, 32'h0);
    expect_run(1'b1, 32'h8000_0060, 32'h0, 1023, 2'd3);
    kick(2'd2);
    wait_idle();
    cfg_read(2'd1, rd); chk(rd == 32'h3FF, "R4 byte limit runs", rd, 32'h3FF);
    load_live(32'h8000_0060, 32'h0, 32'h0000_07FF, 32'h0);
    expect_run(1'b1, 32'h8000_0060, 32'h0, 2047, 2'd0);
    kick(2'd2);
    wait_idle();
    cfg_read(2'd1, rd); chk(rd == 32'h1FFC, "R4 word limit runs", rd, 32'h1FFC);
    chk(err_n == e0, "R5 no error at limits", err_n, e0);
    chk(exp_q.size() == 0, "R4 limit elements", exp_q.size(), 0);

    // writes and starts while busy are ignored
    load_live(32'h8000_0070, 32'h80, 32'h0000_0004, 32'h1);
    expect_run(1'b1, 32'h8000_0070, 32'h80, 4, 2'd0);
    kick(2'd2);
    repeat (3) tick();
    cfg_write(2'd1, 32'h3F0);
    kick(2'd1);
    wait_idle();
    cfg_read(2'd1, rd); chk(rd == 32'h90, "R2 busy write ignored", rd, 32'h90);
    chk(exp_q.size() == 0, "R3 busy start ignored", exp_q.size(), 0);

    // abort
    sb_on = 1'b0;
    load_live(32'h8000_0080, 32'h0, 32'h0000_00C8, 32'h1);
    d0 = done_n;
    kick(2'd2);
    repeat (20) tick();
    mode = 2'd0;
    tick();
    chk(status == 2'd0, "R11 idle after abort", 32'(status), 0);
    tick();
    w0 = wr_cnt;
    repeat (20) tick();
    chk(wr_cnt == w0, "R11 no writes after abort", wr_cnt, w0);
    chk(!mem_req, "R11 no request after abort", 32'(mem_req), 0);
    chk(done_n == d0, "R11 no done after abort", done_n, d0);
    sb_on = 1'b1;
    kick(2'd0);
    chk(status == 2'd0, "R3 start with mode off ignored", 32'(status), 0);
    kick(2'd3);
    chk(status == 2'd0, "R3 start with mode 3 ignored", 32'(status), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule